// File: doc/BRIEF.md
# Fuse Word Auto-Read Engine

This block reads one 32-bit word out of a one-time-programmable fuse array in response to a single register write. Software writes the command register with a word address and two trigger bits. The engine then runs a self-timed read of fixed length. It places the word in a result register and raises a sticky completion flag. Software never drives the array strobe itself. It polls the flag, fetches the word, and clears the flag by writing a one to it before it issues the next word.

The fuse array is modelled inside the block as a computed function of the word address and a seed parameter. The register file sits on a simple single-cycle write port with a combinational read path. The byte offsets stay where driver software expects them: status at 0x18, result at 0x20 and command at 0x24.

Top module: `efuse_autoread`

## Requirements
- R1: After reset the command, status and result registers all read as zero.
- R2: A command-register write (offset 0x24) accepted while idle stores the enable bit (bit 0), the read bit (bit 1) and the 10-bit word address (bits 25:16). The command register reads back those fields in the same positions, with every other bit zero.
- R3: A read starts only when one write sets both bit 0 and bit 1. A write that sets only one of them starts nothing, and the finish flag stays 0.
- R4: The finish flag (status bit 0, offset 0x18) becomes 1 exactly LAT clock edges after the edge that accepted the command (default LAT = 16). It reads 0 at every earlier point. The result register is updated on that same edge.
- R5: The word returned for address a is SEED ^ {6'b0, a, 6'b0, ~a}. Here a fills bits 25:16, ~a fills bits 9:0, and the default SEED is 32'hC3A50F96.
- R6: When a read finishes, the enable and read bits return to 0 and the address field keeps its value.
- R7: A status write with bit 0 set clears the finish flag, and a status write with bit 0 clear leaves the flag unchanged. An accepted command also clears the flag.
- R8: While a read is in progress, command-register writes have no effect: they change neither the stored fields nor the word fetched, and they start no second read. During that time the status reads 0.
- R9: The result register (offset 0x20) holds its value until the next read finishes. Offsets other than 0x18, 0x20 and 0x24 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |

## Verification
The hardest case to reach from the ports is a command write that lands in the middle of a read already in progress. If the design lets such a write slip through, it can alter the address used, or it can cause a second completion after the first one is cleared. The bench launches a read and writes a different address with both trigger bits set a few cycles later. It then checks that the command register still shows the first address and the result matches that address. After clearing the flag, it waits longer than a full read time to confirm that no second completion appears.

// File: rtl/efuse_autoread.sv
module efuse_autoread #(
  parameter int          LAT  = 16,
  parameter logic [31:0] SEED = 32'hC3A5_0F96
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam logic [7:0] OFF_STAT = 8'h18;
  localparam logic [7:0] OFF_DATA = 8'h20;
  localparam logic [7:0] OFF_CMD  = 8'h24;
  localparam int AW = 10;
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(LAT - 1);

  logic          busy, done, cmd_en, cmd_rd;
  logic [AW-1:0] cmd_addr;
  logic [CW-1:0] cnt;
  logic [31:0]   data_q;

  function automatic logic [31:0] fuse_word(input logic [AW-1:0] a);
    return SEED ^ {6'b0, a, 6'b0, ~a};
  endfunction

  wire wr_cmd  = reg_wr && (reg_addr == OFF_CMD);
  wire wr_stat = reg_wr && (reg_addr == OFF_STAT);
  wire start   = wr_cmd && !busy && reg_wdata[0] && reg_wdata[1];
  wire finish  = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cmd_en   <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_addr <= '0;
      cnt      <= '0;
      data_q   <= '0;
    end else begin
      if (wr_cmd && !busy) begin
        cmd_en   <= reg_wdata[0];
        cmd_rd   <= reg_wdata[1];
        cmd_addr <= reg_wdata[16 +: AW];
      end
      if (wr_stat && reg_wdata[0])
        done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= CNT_INIT;
        done <= 1'b0;
      end else if (finish) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        data_q <= fuse_word(cmd_addr);
        cmd_en <= 1'b0;
        cmd_rd <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_STAT: reg_rdata = {31'b0, done};
      OFF_DATA: reg_rdata = data_q;
      OFF_CMD:  reg_rdata = {6'b0, cmd_addr, 14'b0, cmd_rd, cmd_en};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

module efuse_autoread_chk #(
  parameter int LAT = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        busy,
  input logic        done,
  input logic        cmd_en,
  input logic        cmd_rd,
  input logic [9:0]  cmd_addr,
  input logic [31:0] data_q
);
  int bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else bcnt <= 0;
  end

  assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < LAT));
  assert_finish_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_trigger_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!cmd_en && !cmd_rd));
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h18 && reg_wdata[0] && !busy) |=> !done);
  assert_no_flag_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  assert_ignore_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 8'h24) |=> $stable(cmd_addr));
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(data_q));
endmodule

bind efuse_autoread efuse_autoread_chk #(.LAT(LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .done(done), .cmd_en(cmd_en),
  .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .data_q(data_q)
);

// File: tb/efuse_autoread_tb.sv
module efuse_autoread_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          LAT        = 16;
  localparam logic [31:0] SEED       = 32'hC3A5_0F96;
  localparam int          NVEC       = 6;
  localparam logic [9:0]  VEC_ADDR [NVEC] = '{10'h000, 10'h001, 10'h3FF, 10'h155, 10'h2AA, 10'h060};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  efuse_autoread #(.LAT(LAT), .SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expect_word(input logic [9:0] a);
    logic [31:0] pat;
    pat = 32'h0;
    pat[25:16] = a;
    pat[9:0]   = ~a;
    return SEED ^ pat;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] cmd(input logic [9:0] a, input bit en, input bit r);
    return {6'b0, a, 14'b0, r, en};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    expect_reg(8'h18, 32'h0, "R1 status");
    expect_reg(8'h20, 32'h0, "R1 result");
    expect_reg(8'h24, 32'h0, "R1 command");
    rst_n = 1'b1;
    wait_cyc(2);

    for (int i = 0; i < NVEC; i++) begin
      wr(8'h24, cmd(VEC_ADDR[i], 1, 1));
      wait_cyc(LAT - 1);
      expect_reg(8'h18, 32'h0, "R4 flag early");
      wait_cyc(1);
      expect_reg(8'h18, 32'h1, "R4 flag on time");
      expect_reg(8'h20, expect_word(VEC_ADDR[i]), "R5 word");
      expect_reg(8'h24, cmd(VEC_ADDR[i], 0, 0), "R6 triggers cleared");
      wr(8'h18, 32'h1);
      expect_reg(8'h18, 32'h0, "R7 clear");
      expect_reg(8'h20, expect_word(VEC_ADDR[i]), "R9 hold after clear");
    end

    wr(8'h24, cmd(10'h123, 1, 0));
    expect_reg(8'h24, 32'h0123_0001, "R2 readback enable only");
    wait_cyc(LAT + 4);
    expect_reg(8'h18, 32'h0, "R3 enable only no start");
    expect_reg(8'h20, expect_word(10'h060), "R3 result unchanged");
    wr(8'h24, cmd(10'h2C7, 0, 1) | 32'hFC00_FFFC);
    expect_reg(8'h24, 32'h02C7_0002, "R2 readback read only, other bits zero");
    wait_cyc(LAT + 4);
    expect_reg(8'h18, 32'h0, "R3 read only no start");

    wr(8'h24, cmd(10'h0AB, 1, 1));
    wait_cyc(3);
    wr(8'h24, cmd(10'h3C3, 1, 1));
    expect_reg(8'h24, cmd(10'h0AB, 1, 1), "R8 busy write ignored");
    expect_reg(8'h18, 32'h0, "R8 status zero while busy");
    wait_cyc(LAT);
    expect_reg(8'h18, 32'h1, "R8 first read finished");
    expect_reg(8'h20, expect_word(10'h0AB), "R8 word from first address");
    wr(8'h18, 32'h0);
    expect_reg(8'h18, 32'h1, "R7 write zero keeps flag");
    wr(8'h18, 32'h1);
    wait_cyc(LAT + 4);
    expect_reg(8'h18, 32'h0, "R8 no second finish");

    wr(8'h24, cmd(10'h011, 1, 1));
    wait_cyc(LAT);
    expect_reg(8'h18, 32'h1, "R4 flag set");
    wr(8'h24, cmd(10'h022, 1, 1));
    expect_reg(8'h18, 32'h0, "R7 command clears flag");
    expect_reg(8'h20, expect_word(10'h011), "R9 hold while next read runs");
    wait_cyc(LAT);
    expect_reg(8'h20, expect_word(10'h022), "R5 next word");
    expect_reg(8'h00, 32'h0, "R9 unmapped offset");
    expect_reg(8'h1C, 32'h0, "R9 unmapped offset");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule